// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer with Seconds or Minutes Units

This block is a watchdog counter that lives in a small configuration register space. Software programs a timeout count, a configuration byte and a control byte through per-register write strobes that an outside bus decoder supplies. The counter steps down once per unit tick. The unit is one second, taken straight from a one-cycle seconds strobe, or one minute, made by an internal divide-by-60 prescaler that counts those strobes. Software keeps the system alive by rewriting the count before it runs out. Each write to a count byte reloads the running counter from the programmed value.

When a decrement brings the counter from one to zero, a sticky expiry flag sets in the control byte. While that flag stays set, each expiry action enabled in the configuration byte is driven: a keyboard-style reset request, a power-good pull-down and a timeout event. The configuration byte also carries a 4-bit interrupt line select, which is passed out unchanged. A programmed count of zero means the timer is stopped, so it never expires. A parameter sets the count width to 16 bits or to 8 bits. In the 8-bit variant the high count byte does not exist.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the configuration byte, the control byte, the programmed value and the running count are all zero, kbRstOut and toEvtOut are low and pwrGoodOut is high.
- R2: A strobe on valLoWr (or valHiWr in the 16-bit variant) replaces that byte of the programmed value with wrData. One cycle later the running count equals the whole new programmed value. The same write clears the expiry flag and the minutes prescaler.
- R3: With configuration bit 7 set (seconds mode), every secTick strobe lowers a non-zero running count by exactly one.
- R4: With configuration bit 7 clear (minutes mode), the count drops by one on every 60th secTick strobe counted from the last reload. The preceding 59 strobes leave it unchanged.
- R5: A decrement from 1 to 0 sets control bit 0 (the expiry flag) one cycle later. Further ticks leave the flag set and the count at zero.
- R6: While the expiry flag is set, kbRstOut is high if configuration bit 6 is set, pwrGoodOut is low if configuration bit 4 is set, and toEvtOut is high if configuration bit 5 is set. An output whose enable bit is clear stays inactive.
- R7: A programmed count of zero stops the timer: no number of ticks sets the expiry flag or changes the count.
- R8: A control write of 0x00 clears the expiry flag and with it every expiry output. A control write of any non-zero value leaves the flag as it was.
- R9: When a count-byte write and a unit tick fall in the same cycle, the write wins. The count becomes the new value and is not decremented.
- R10: With VAL_W = 8, valHiWr is ignored: the programmed value and the count keep their contents and reload nothing.
- R11: cfgRd returns the last byte written with cfgWr, and irqSel equals configuration bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-cycle strobe once per second |
| cfgWr | input | 1 | Write strobe for the configuration byte |
| ctrlWr | input | 1 | Write strobe for the control byte |
| valLoWr | input | 1 | Write strobe for the count low byte |
| valHiWr | input | 1 | Write strobe for the count high byte |
| wrData | input | 8 | Write data for all strobes |
| cfgRd | output | 8 | Configuration byte |
| ctrlRd | output | 8 | Control byte, bit 0 is the expiry flag |
| valueRd | output | VAL_W | Programmed timeout value |
| countRd | output | VAL_W | Running count |
| kbRstOut | output | 1 | Reset request, active high |
| pwrGoodOut | output | 1 | Power-good, pulled low on enabled expiry |
| toEvtOut | output | 1 | Timeout event, active high |
| irqSel | output | 4 | Interrupt line select |

## Verification
In seconds mode a table of counts and tick totals is applied. It covers a partial countdown, an exact run to zero, a count of one, a count that crosses the low byte, the all-ones count and a zero count. Together these separate a correct decrement from off-by-one expiry, a lost high byte and a zero count that wrongly fires. Minutes-mode runs with 59 and 60 strobes, plus a reload part-way through a minute, show whether the prescaler divides by 60 and clears on reload. Further cases cover the enable bits taken one at a time, a write and a tick in the same cycle, clearing the control byte, and a second instance with an 8-bit count. Each of these isolates one expiry-output path or one priority rule.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // strobes from the control module to the datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic dec;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int VAL_W   = 16,
  parameter int MIN_DIV = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       cfgWr,
  input  logic       ctrlWr,
  input  logic       valLoWr,
  input  logic       valHiWr,
  input  logic [7:0] wrData,
  input  logic       cntZero,
  input  logic       cntOne,
  output wdtStrobe_t stb,
  output logic [7:0] cfgQ,
  output logic       expFlag
);
  localparam int  PRE_W  = $clog2(MIN_DIV);
  localparam logic HAS_HI = (VAL_W > 8);

  logic [PRE_W-1:0] preCnt;
  logic reload, unitTick, preWrap;

  assign preWrap  = (preCnt == PRE_W'(MIN_DIV - 1));
  assign reload   = valLoWr | (valHiWr & HAS_HI);
  assign unitTick = secTick & (cfgQ[7] | preWrap);

  always_comb begin
    stb.loadLo = valLoWr;
    stb.loadHi = valHiWr & HAS_HI;
    stb.dec    = unitTick & ~reload & ~cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      preCnt  <= '0;
      expFlag <= 1'b0;
    end else begin
      if (cfgWr) cfgQ <= wrData;

      if (reload)                  preCnt <= '0;
      else if (secTick && !cfgQ[7]) preCnt <= preWrap ? '0 : preCnt + 1'b1;

      if (reload)                      expFlag <= 1'b0;
      else if (stb.dec && cntOne)      expFlag <= 1'b1;
      else if (ctrlWr && wrData == '0) expFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       stb,
  input  logic [7:0]       wrData,
  output logic [VAL_W-1:0] valueQ,
  output logic [VAL_W-1:0] countQ,
  output logic             cntZero,
  output logic             cntOne
);
  logic [VAL_W-1:0] valueNext;

  generate
    if (VAL_W > 8) begin : gWide
      localparam int HI_W = VAL_W - 8;
      assign valueNext = {stb.loadHi ? wrData[HI_W-1:0] : valueQ[VAL_W-1:8],
                          stb.loadLo ? wrData : valueQ[7:0]};
    end else begin : gNarrow
      logic hiUnused;
      assign hiUnused  = stb.loadHi;
      assign valueNext = stb.loadLo ? wrData[VAL_W-1:0] : valueQ;
    end
  endgenerate

  assign cntZero = (countQ == '0);
  assign cntOne  = (countQ == VAL_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valueQ <= '0;
      countQ <= '0;
    end else if (stb.loadLo || stb.loadHi) begin
      valueQ <= valueNext;
      countQ <= valueNext;
    end else if (stb.dec) begin
      countQ <= countQ - VAL_W'(1);
    end
  end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdt_pkg::*;
#(
  parameter int VAL_W   = 16,
  parameter int MIN_DIV = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             cfgWr,
  input  logic             ctrlWr,
  input  logic             valLoWr,
  input  logic             valHiWr,
  input  logic [7:0]       wrData,
  output logic [7:0]       cfgRd,
  output logic [7:0]       ctrlRd,
  output logic [VAL_W-1:0] valueRd,
  output logic [VAL_W-1:0] countRd,
  output logic             kbRstOut,
  output logic             pwrGoodOut,
  output logic             toEvtOut,
  output logic [3:0]       irqSel
);
  wdtStrobe_t stb;
  logic cntZero, cntOne, expFlag;

  wdt_ctrl #(.VAL_W(VAL_W), .MIN_DIV(MIN_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .cfgWr(cfgWr),
    .ctrlWr(ctrlWr), .valLoWr(valLoWr), .valHiWr(valHiWr),
    .wrData(wrData), .cntZero(cntZero), .cntOne(cntOne),
    .stb(stb), .cfgQ(cfgRd), .expFlag(expFlag)
  );

  wdt_datapath #(.VAL_W(VAL_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .valueQ(valueRd), .countQ(countRd), .cntZero(cntZero), .cntOne(cntOne)
  );

  assign ctrlRd     = {7'b0, expFlag};
  assign kbRstOut   = expFlag & cfgRd[6];
  assign pwrGoodOut = ~(expFlag & cfgRd[4]);
  assign toEvtOut   = expFlag & cfgRd[5];
  assign irqSel     = cfgRd[3:0];
endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             secTick,
  input logic             ctrlWr,
  input logic             valLoWr,
  input logic             valHiWr,
  input logic [7:0]       wrData,
  input logic [7:0]       cfgRd,
  input logic [7:0]       ctrlRd,
  input logic [VAL_W-1:0] countRd,
  input logic             kbRstOut,
  input logic             pwrGoodOut
);
  // R2: low-byte write reloads the count's low byte
  a_r2_reload_low: assert property (@(posedge clk) disable iff (!rstN)
    valLoWr |=> countRd[7:0] == $past(wrData[7:0]));

  // R3: seconds-mode tick steps the count down by one
  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && cfgRd[7] && !valLoWr && !valHiWr && countRd != '0)
      |=> countRd == $past(countRd) - VAL_W'(1));

  // R5: last step sets the expiry flag
  a_r5_expire: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && cfgRd[7] && !valLoWr && !valHiWr && countRd == VAL_W'(1))
      |=> ctrlRd[0]);

  // R5: flag is sticky without a clearing write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[0] && !valLoWr && !valHiWr && !(ctrlWr && wrData == 8'h00))
      |=> ctrlRd[0]);

  // R7: a stopped timer stays stopped and silent
  a_r7_zero_stops: assert property (@(posedge clk) disable iff (!rstN)
    (countRd == '0 && !ctrlRd[0] && !valLoWr && !valHiWr)
      |=> (countRd == '0 && !ctrlRd[0]));

  // R6: expiry outputs only while flagged
  a_r6_kb_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    kbRstOut |-> ctrlRd[0]);
  a_r6_pg_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGoodOut |-> ctrlRd[0]);
endmodule

bind tick_watchdog tick_watchdog_chk #(.VAL_W(VAL_W)) uChk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .ctrlWr(ctrlWr),
  .valLoWr(valLoWr), .valHiWr(valHiWr), .wrData(wrData), .cfgRd(cfgRd),
  .ctrlRd(ctrlRd), .countRd(countRd), .kbRstOut(kbRstOut),
  .pwrGoodOut(pwrGoodOut)
);

// File: tb/sim_tick_watchdog.sv
`timescale 1ns/1ps
module sim_tick_watchdog;
  logic clk = 0, rstN = 0;
  logic secTick = 0, cfgWr = 0, ctrlWr = 0, valLoWr = 0, valHiWr = 0;
  logic [7:0] wrData = 0;

  logic [7:0]  cfgRd, ctrlRd, cfgRd8, ctrlRd8;
  logic [15:0] valueRd, countRd;
  logic [7:0]  valueRd8, countRd8;
  logic kbRstOut, pwrGoodOut, toEvtOut, kb8, pg8, te8;
  logic [3:0] irqSel, irq8;

  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  tick_watchdog #(.VAL_W(16)) u0 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .cfgWr(cfgWr), .ctrlWr(ctrlWr),
    .valLoWr(valLoWr), .valHiWr(valHiWr), .wrData(wrData), .cfgRd(cfgRd),
    .ctrlRd(ctrlRd), .valueRd(valueRd), .countRd(countRd), .kbRstOut(kbRstOut),
    .pwrGoodOut(pwrGoodOut), .toEvtOut(toEvtOut), .irqSel(irqSel));

  tick_watchdog #(.VAL_W(8)) u1 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .cfgWr(cfgWr), .ctrlWr(ctrlWr),
    .valLoWr(valLoWr), .valHiWr(valHiWr), .wrData(wrData), .cfgRd(cfgRd8),
    .ctrlRd(ctrlRd8), .valueRd(valueRd8), .countRd(countRd8), .kbRstOut(kb8),
    .pwrGoodOut(pg8), .toEvtOut(te8), .irqSel(irq8));

  // {load value, number of ticks, expected count, expected flag}
  typedef struct packed {
    logic [15:0] val;
    logic [15:0] ticks;
    logic [15:0] expCnt;
    logic        expFlag;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'd5,     16'd3,  16'd2,     1'b0},
    '{16'd5,     16'd5,  16'd0,     1'b1},
    '{16'd1,     16'd1,  16'd0,     1'b1},
    '{16'd300,   16'd45, 16'd255,   1'b0},
    '{16'd0,     16'd7,  16'd0,     1'b0},
    '{16'hFFFF,  16'd2,  16'hFFFD,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [7:0] d);
    @(negedge clk); cfgWr = 1; wrData = d; @(negedge clk); cfgWr = 0;
  endtask
  task automatic wrCtrl(input logic [7:0] d);
    @(negedge clk); ctrlWr = 1; wrData = d; @(negedge clk); ctrlWr = 0;
  endtask
  task automatic wrLo(input logic [7:0] d);
    @(negedge clk); valLoWr = 1; wrData = d; @(negedge clk); valLoWr = 0;
  endtask
  task automatic wrHi(input logic [7:0] d);
    @(negedge clk); valHiWr = 1; wrData = d; @(negedge clk); valHiWr = 0;
  endtask
  task automatic load(input logic [15:0] v);
    wrLo(v[7:0]); wrHi(v[15:8]);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1; @(negedge clk); secTick = 0;
    end
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cfg", cfgRd, 0);
    check("R1 ctrl", ctrlRd, 0);
    check("R1 value", valueRd, 0);
    check("R1 count", countRd, 0);
    check("R1 kbRst", kbRstOut, 0);
    check("R1 pwrGood", pwrGoodOut, 1);
    check("R1 toEvt", toEvtOut, 0);
    rstN = 1;
    @(negedge clk);

    // R3/R5/R6/R7 seconds-mode table, bits 7,6,4 set
    wrCfg(8'hD0);
    for (int k = 0; k < NV; k++) begin
      load(VECS[k].val);
      check("R2 reload", countRd, VECS[k].val);
      check("R2 flag cleared", ctrlRd, 0);
      ticks(VECS[k].ticks);
      check("R3 count", countRd, VECS[k].expCnt);
      check("R5 flag", ctrlRd[0], VECS[k].expFlag);
      check("R6 kbRst", kbRstOut, VECS[k].expFlag);
      check("R6 pwrGood", pwrGoodOut, !VECS[k].expFlag);
      check("R6 toEvt off", toEvtOut, 0);
    end

    // R5 sticky after more ticks
    load(16'd2); ticks(2); ticks(4);
    check("R5 sticky flag", ctrlRd, 8'h01);
    check("R5 count held", countRd, 0);
    // R8 nonzero ctrl write keeps flag, zero clears
    wrCtrl(8'h01);
    check("R8 nonzero keeps", ctrlRd, 8'h01);
    wrCtrl(8'h00);
    check("R8 zero clears", ctrlRd, 8'h00);
    check("R8 kbRst off", kbRstOut, 0);
    check("R8 pwrGood on", pwrGoodOut, 1);

    // R7 zero count never fires
    load(16'd0); ticks(20);
    check("R7 no expiry", ctrlRd, 0);

    // R9 write and tick in same cycle
    load(16'd10);
    @(negedge clk); valLoWr = 1; secTick = 1; wrData = 8'd7;
    @(negedge clk); valLoWr = 0; secTick = 0;
    check("R9 write wins", countRd, 16'd7);

    // R4 minutes mode, only bit 6 enabled
    wrCfg(8'h40);
    load(16'd2);
    ticks(59);
    check("R4 59 strobes no step", countRd, 2);
    ticks(1);
    check("R4 60th strobe steps", countRd, 1);
    ticks(60);
    check("R5 minute expiry", ctrlRd, 8'h01);
    check("R6 kbRst bit6", kbRstOut, 1);
    check("R6 pwrGood bit4 clear", pwrGoodOut, 1);
    // R4 prescaler clears on reload
    load(16'd3); ticks(30);
    load(16'd3); ticks(59);
    check("R4 prescaler cleared", countRd, 3);
    ticks(1);
    check("R4 after clear", countRd, 2);

    // R6 timeout event only, R11 readback
    wrCfg(8'hA5);
    check("R11 cfg readback", cfgRd, 8'hA5);
    check("R11 irqSel", irqSel, 4'h5);
    load(16'd1); ticks(1);
    check("R6 toEvt bit5", toEvtOut, 1);
    check("R6 kbRst disabled", kbRstOut, 0);
    check("R6 pwrGood disabled", pwrGoodOut, 1);

    // R10 narrow variant ignores high byte
    wrLo(8'd9);
    check("R10 narrow load", countRd8, 8'd9);
    ticks(2);
    wrHi(8'h33);
    check("R10 hi ignored value", valueRd8, 8'd9);
    check("R10 hi ignored count", countRd8, 8'd7);
    check("R2 wide hi reload", countRd, 16'h3309);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule